// File: doc/BRIEF.md
# Descriptor queue manager

This block keeps the state of a small set of circular descriptor rings that live in host memory and hands out descriptor addresses from them. Software sets up each ring (base address, size, completion ring index, active bit, producer index, consumer index) through an AXI4-Lite style register port. The port carries only address, data and the valid/ready pairs; every response is OKAY, so no response code fields exist. Writing a ring's producer index emits that ring's number on a doorbell output for one cycle.

A consumer engine sends dequeue requests that each name a ring and carry a tag. For each request the block returns one response. The response carries either the next descriptor's address and index together with a freshly allocated operation tag, or an empty indication, or an error indication. The handout is speculative. A private speculative consumer index advances at once. The consumer index that software reads only moves when the engine later sends a commit carrying that operation tag, which also frees the tag. Operation tags come from a 16-entry table, and the request port stalls while every entry is in use.

Two state machines drive the block. The dequeue machine moves DQ_ACCEPT → DQ_EVAL when a request is taken, DQ_EVAL → DQ_RESPOND unconditionally, and DQ_RESPOND → DQ_ACCEPT when the response is taken. The register machine moves CS_IDLE → CS_WRESP on a write (writes win over reads), CS_IDLE → CS_RRESP on a read, and back to CS_IDLE when the response is taken.

Top module: `desc_queue_mgr`

## Requirements
- R1: After reset, req_ready is 1, resp_valid, csr_bvalid, csr_rvalid and doorbell_valid are 0, commit_ready is 1, and every register reads 0.
- R2: Ring q occupies byte offsets q*32 + {0,4,8,12,16}. These hold, in turn: base address bits 31:0, base bits 63:32, control (bit 31 active, bits 15:8 completion ring index, bits 3:0 log2 ring size), producer index (bits 15:0) and committed consumer index (bits 15:0). A write is accepted when awvalid and wvalid are both high in CS_IDLE, and csr_bvalid rises on the next cycle. A read returns data with csr_rvalid on the next cycle. Writes to an unaligned address or to a ring number of QUEUES or above change nothing, and reads of them return 0.
- R3: An accepted write of a producer index to a valid ring gives doorbell_valid high for exactly the next cycle, with doorbell_queue equal to that ring number.
- R4: A request taken at clock edge k gives resp_valid from edge k+1 onward. The response fields stay constant until resp_ready is seen high, and req_ready is low from edge k until the response is taken.
- R5: For an active ring whose producer index differs from its speculative consumer index P, the response carries ptr = P and addr = base + ((P mask (2^log - 1)) << 4). It also carries the completion ring index, the echoed queue and tag, empty = 0, error = 0, and op_tag = the lowest free table entry. P then advances by 1 modulo 2^16.
- R6: When the producer index equals the speculative consumer index, the response has empty = 1, error = 0, op_tag = 0, and ptr, addr and cpl as in R5. No entry is allocated.
- R7: A request naming an inactive ring, a ring number of QUEUES or above, or any request made while enable is low, gets error = 1, empty = 0, and ptr, addr, cpl and op_tag all 0. Nothing is allocated.
- R8: A commit naming a busy table entry frees that entry and advances the owning ring's committed consumer index by 1 modulo 2^16. A commit naming a free entry or a value of 16 or above changes nothing.
- R9: While all 16 entries are busy, req_ready is 0. It returns to 1 on the cycle after a commit frees an entry.
- R10: Writing the consumer index register sets both the committed and the speculative consumer index of that ring.
- R11: A committed consumer index of 0xFFFF becomes 0x0000 on commit, and the descriptor offset wraps within the ring size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global dequeue enable |
| req_queue | input | 8 | Ring number of a dequeue request |
| req_tag | input | 8 | Request tag, echoed back |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted |
| resp_queue | output | 8 | Echoed ring number |
| resp_ptr | output | 16 | Speculative consumer index handed out |
| resp_addr | output | 64 | Descriptor address |
| resp_cpl | output | 8 | Completion ring index |
| resp_tag | output | 8 | Echoed request tag |
| resp_op_tag | output | 8 | Allocated operation tag |
| resp_empty | output | 1 | Ring had nothing to hand out |
| resp_error | output | 1 | Request refused |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response taken |
| commit_tag | input | 8 | Operation tag to retire |
| commit_valid | input | 1 | Commit valid |
| commit_ready | output | 1 | Always 1 |
| doorbell_queue | output | 8 | Ring whose producer index was written |
| doorbell_valid | output | 1 | One-cycle doorbell pulse |
| csr_awaddr | input | 16 | Write byte address |
| csr_awvalid | input | 1 | Write address valid |
| csr_awready | output | 1 | Write address taken |
| csr_wdata | input | 32 | Write data |
| csr_wvalid | input | 1 | Write data valid |
| csr_wready | output | 1 | Write data taken |
| csr_bvalid | output | 1 | Write response valid |
| csr_bready | input | 1 | Write response taken |
| csr_araddr | input | 16 | Read byte address |
| csr_arvalid | input | 1 | Read address valid |
| csr_arready | output | 1 | Read address taken |
| csr_rdata | output | 32 | Read data |
| csr_rvalid | output | 1 | Read data valid |
| csr_rready | input | 1 | Read data taken |

## Verification
A dequeue response is due one edge after the accepting edge. A write response, a read value and a doorbell pulse are each due on the edge that accepts the register access. A commit shows in req_ready and in the consumer index register from the edge that takes it. The bench drives inputs and samples outputs only at falling edges. It updates its behavioural model at the falling edge that follows the edge where the design commits the change, so every comparison lands on the cycle where the requirement places the result. req_ready, resp_valid and the doorbell are compared against the model on every clock.

// File: rtl/dqm_pkg.sv
package dqm_pkg;
    typedef enum logic [1:0] {DQ_ACCEPT, DQ_EVAL, DQ_RESPOND} dq_state_t;
    typedef enum logic [1:0] {CS_IDLE, CS_WRESP, CS_RRESP} cs_state_t;

    localparam logic [2:0] RG_BASE_LO = 3'd0;
    localparam logic [2:0] RG_BASE_HI = 3'd1;
    localparam logic [2:0] RG_CTRL    = 3'd2;
    localparam logic [2:0] RG_HEAD    = 3'd3;
    localparam logic [2:0] RG_TAIL    = 3'd4;
    localparam int         CPL_LSB    = 8;
    localparam int         STRIDE_LOG = 5;
endpackage

// File: rtl/dqm_csr.sv
module dqm_csr
    import dqm_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int QSEL_W = AW - STRIDE_LOG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DW-1:0]     wdata,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    input  logic [AW-1:0]     araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DW-1:0]     rdata,
    output logic              rvalid,
    input  logic              rready,
    output logic              wr_en,
    output logic [QSEL_W-1:0] wr_queue,
    output logic [2:0]        wr_reg,
    output logic [DW-1:0]     wr_data,
    output logic [QSEL_W-1:0] rd_queue,
    output logic [2:0]        rd_reg,
    input  logic [DW-1:0]     rd_value
);
    cs_state_t st, st_nx;
    logic      wr_go, rd_go;

    assign wr_go = (st == CS_IDLE) && awvalid && wvalid;
    assign rd_go = (st == CS_IDLE) && arvalid && !(awvalid && wvalid);

    always_comb begin
        st_nx = st;
        unique case (st)
            CS_IDLE:  if (wr_go) st_nx = CS_WRESP; else if (rd_go) st_nx = CS_RRESP;
            CS_WRESP: if (bready) st_nx = CS_IDLE;
            CS_RRESP: if (rready) st_nx = CS_IDLE;
            default:  st_nx = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= CS_IDLE;
        else     st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_go) rdata <= (araddr[1:0] == 2'b00) ? rd_value : '0;
    end

    always_comb begin
        awready  = wr_go;
        wready   = wr_go;
        arready  = rd_go;
        bvalid   = (st == CS_WRESP);
        rvalid   = (st == CS_RRESP);
        wr_en    = wr_go && (awaddr[1:0] == 2'b00);
        wr_queue = awaddr[AW-1:STRIDE_LOG];
        wr_reg   = awaddr[4:2];
        wr_data  = wdata;
        rd_queue = araddr[AW-1:STRIDE_LOG];
        rd_reg   = araddr[4:2];
    end

    assert_wresp_hold_R2: assert property (@(posedge clk) disable iff (rst)
        bvalid && !bready |=> bvalid);
    assert_rresp_hold_R2: assert property (@(posedge clk) disable iff (rst)
        rvalid && !rready |=> rvalid && $stable(rdata));
endmodule

// File: rtl/dqm_optable.sv
module dqm_optable #(
    parameter int DEPTH = 16,
    parameter int QSW   = 2,
    parameter int TW    = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           alloc_en,
    input  logic [QSW-1:0] alloc_q,
    output logic [IW-1:0]  alloc_idx,
    output logic           full,
    input  logic           commit_en,
    input  logic [TW-1:0]  commit_tag,
    output logic           retire_hit,
    output logic [QSW-1:0] retire_q
);
    logic [DEPTH-1:0] busy;
    logic [QSW-1:0]   owner [DEPTH];
    logic [IW-1:0]    ctag;

    assign ctag       = commit_tag[IW-1:0];
    assign full       = &busy;
    assign retire_hit = commit_en && (commit_tag < TW'(DEPTH)) && busy[ctag];
    assign retire_q   = owner[ctag];

    // lowest free entry wins
    always_comb begin
        alloc_idx = '0;
        for (int e = DEPTH - 1; e >= 0; e--)
            if (!busy[e]) alloc_idx = IW'(e);
    end

    always_ff @(posedge clk) begin
        if (rst) busy <= '0;
        else begin
            if (alloc_en)   busy[alloc_idx] <= 1'b1;
            if (retire_hit) busy[ctag]      <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_en) owner[alloc_idx] <= alloc_q;
    end

    assert_alloc_free_R9: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> !full);
    assert_retire_clears_R8: assert property (@(posedge clk) disable iff (rst)
        retire_hit |=> !full);
endmodule

// File: rtl/desc_queue_mgr.sv
module desc_queue_mgr
    import dqm_pkg::*;
#(
    parameter int QUEUES     = 4,
    parameter int QIW        = 8,
    parameter int REQ_TAG_W  = 8,
    parameter int OP_TAG_W   = 8,
    parameter int CPL_W      = 8,
    parameter int PTR_W      = 16,
    parameter int LOG_W      = 4,
    parameter int ADDR_W     = 64,
    parameter int OPS        = 16,
    parameter int DESC_SHIFT = 4,
    parameter int REG_AW     = 16,
    parameter int REG_DW     = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic [QIW-1:0]       req_queue,
    input  logic [REQ_TAG_W-1:0] req_tag,
    input  logic                 req_valid,
    output logic                 req_ready,
    output logic [QIW-1:0]       resp_queue,
    output logic [PTR_W-1:0]     resp_ptr,
    output logic [ADDR_W-1:0]    resp_addr,
    output logic [CPL_W-1:0]     resp_cpl,
    output logic [REQ_TAG_W-1:0] resp_tag,
    output logic [OP_TAG_W-1:0]  resp_op_tag,
    output logic                 resp_empty,
    output logic                 resp_error,
    output logic                 resp_valid,
    input  logic                 resp_ready,
    input  logic [OP_TAG_W-1:0]  commit_tag,
    input  logic                 commit_valid,
    output logic                 commit_ready,
    output logic [QIW-1:0]       doorbell_queue,
    output logic                 doorbell_valid,
    input  logic [REG_AW-1:0]    csr_awaddr,
    input  logic                 csr_awvalid,
    output logic                 csr_awready,
    input  logic [REG_DW-1:0]    csr_wdata,
    input  logic                 csr_wvalid,
    output logic                 csr_wready,
    output logic                 csr_bvalid,
    input  logic                 csr_bready,
    input  logic [REG_AW-1:0]    csr_araddr,
    input  logic                 csr_arvalid,
    output logic                 csr_arready,
    output logic [REG_DW-1:0]    csr_rdata,
    output logic                 csr_rvalid,
    input  logic                 csr_rready
);
    localparam int QSEL_W = REG_AW - STRIDE_LOG;
    localparam int QSW    = (QUEUES > 1) ? $clog2(QUEUES) : 1;
    localparam int OPIW   = $clog2(OPS);

    // per-ring state
    logic [ADDR_W-1:0] q_base  [QUEUES];
    logic [LOG_W-1:0]  q_log   [QUEUES];
    logic [CPL_W-1:0]  q_cpl   [QUEUES];
    logic              q_act   [QUEUES];
    logic [PTR_W-1:0]  q_head  [QUEUES];
    logic [PTR_W-1:0]  q_tailc [QUEUES];
    logic [PTR_W-1:0]  q_tails [QUEUES];

    logic              csr_wr;
    logic [QSEL_W-1:0] csr_q, rd_q;
    logic [2:0]        csr_reg, rd_reg;
    logic [REG_DW-1:0] csr_data, rd_val;

    dqm_csr #(.AW(REG_AW), .DW(REG_DW)) u_csr (
        .clk(clk), .rst(rst),
        .awaddr(csr_awaddr), .awvalid(csr_awvalid), .awready(csr_awready),
        .wdata(csr_wdata), .wvalid(csr_wvalid), .wready(csr_wready),
        .bvalid(csr_bvalid), .bready(csr_bready),
        .araddr(csr_araddr), .arvalid(csr_arvalid), .arready(csr_arready),
        .rdata(csr_rdata), .rvalid(csr_rvalid), .rready(csr_rready),
        .wr_en(csr_wr), .wr_queue(csr_q), .wr_reg(csr_reg), .wr_data(csr_data),
        .rd_queue(rd_q), .rd_reg(rd_reg), .rd_value(rd_val)
    );

    // dequeue pipeline state
    dq_state_t            st, st_nx;
    logic [QIW-1:0]       cap_q;
    logic [REQ_TAG_W-1:0] cap_tag;
    logic [QSW-1:0]       qi;
    logic                 q_ok, q_empty, alloc_en, full, retire_hit;
    logic [PTR_W-1:0]     size_mask;
    logic [ADDR_W-1:0]    desc_addr;
    logic [OPIW-1:0]      alloc_idx;
    logic [QSW-1:0]       retire_q;

    assign qi        = cap_q[QSW-1:0];
    assign q_ok      = enable && (cap_q < QIW'(QUEUES)) && q_act[qi];
    assign q_empty   = (q_head[qi] == q_tails[qi]);
    assign size_mask = (PTR_W'(1) << q_log[qi]) - PTR_W'(1);
    assign desc_addr = q_base[qi] + (ADDR_W'(q_tails[qi] & size_mask) << DESC_SHIFT);
    assign alloc_en  = (st == DQ_EVAL) && q_ok && !q_empty;

    dqm_optable #(.DEPTH(OPS), .QSW(QSW), .TW(OP_TAG_W)) u_ops (
        .clk(clk), .rst(rst),
        .alloc_en(alloc_en), .alloc_q(qi), .alloc_idx(alloc_idx), .full(full),
        .commit_en(commit_valid), .commit_tag(commit_tag),
        .retire_hit(retire_hit), .retire_q(retire_q)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            DQ_ACCEPT:  if (req_valid && !full) st_nx = DQ_EVAL;
            DQ_EVAL:    st_nx = DQ_RESPOND;
            DQ_RESPOND: if (resp_ready) st_nx = DQ_ACCEPT;
            default:    st_nx = DQ_ACCEPT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= DQ_ACCEPT;
        else     st <= st_nx;
    end

    always_comb begin
        req_ready    = (st == DQ_ACCEPT) && !full;
        resp_valid   = (st == DQ_RESPOND);
        commit_ready = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0; cap_tag <= '0;
            resp_queue <= '0; resp_tag <= '0; resp_ptr <= '0; resp_addr <= '0;
            resp_cpl <= '0; resp_op_tag <= '0; resp_empty <= 1'b0; resp_error <= 1'b0;
        end else if (st == DQ_ACCEPT && req_valid && !full) begin
            cap_q   <= req_queue;
            cap_tag <= req_tag;
        end else if (st == DQ_EVAL) begin
            resp_queue  <= cap_q;
            resp_tag    <= cap_tag;
            resp_ptr    <= q_ok ? q_tails[qi] : '0;
            resp_addr   <= q_ok ? desc_addr : '0;
            resp_cpl    <= q_ok ? q_cpl[qi] : '0;
            resp_op_tag <= alloc_en ? OP_TAG_W'(alloc_idx) : '0;
            resp_empty  <= q_ok && q_empty;
            resp_error  <= !q_ok;
        end
    end

    // ring state: later assignments win, so register writes beat pipeline updates
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < QUEUES; i++) begin
                q_base[i] <= '0; q_log[i] <= '0; q_cpl[i] <= '0; q_act[i] <= 1'b0;
                q_head[i] <= '0; q_tailc[i] <= '0; q_tails[i] <= '0;
            end
        end else begin
            for (int i = 0; i < QUEUES; i++) begin
                if (alloc_en && qi == QSW'(i))         q_tails[i] <= q_tails[i] + PTR_W'(1);
                if (retire_hit && retire_q == QSW'(i)) q_tailc[i] <= q_tailc[i] + PTR_W'(1);
                if (csr_wr && csr_q == QSEL_W'(i)) begin
                    case (csr_reg)
                        RG_BASE_LO: q_base[i][REG_DW-1:0] <= csr_data;
                        RG_BASE_HI: q_base[i][ADDR_W-1:REG_DW] <= csr_data[ADDR_W-REG_DW-1:0];
                        RG_CTRL: begin
                            q_act[i] <= csr_data[REG_DW-1];
                            q_cpl[i] <= csr_data[CPL_LSB +: CPL_W];
                            q_log[i] <= csr_data[LOG_W-1:0];
                        end
                        RG_HEAD: q_head[i] <= csr_data[PTR_W-1:0];
                        RG_TAIL: begin
                            q_tailc[i] <= csr_data[PTR_W-1:0];
                            q_tails[i] <= csr_data[PTR_W-1:0];
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            doorbell_valid <= 1'b0;
            doorbell_queue <= '0;
        end else begin
            doorbell_valid <= csr_wr && csr_reg == RG_HEAD && csr_q < QSEL_W'(QUEUES);
            if (csr_wr && csr_reg == RG_HEAD) doorbell_queue <= QIW'(csr_q);
        end
    end

    always_comb begin
        rd_val = '0;
        if (rd_q < QSEL_W'(QUEUES)) begin
            case (rd_reg)
                RG_BASE_LO: rd_val = q_base[rd_q[QSW-1:0]][REG_DW-1:0];
                RG_BASE_HI: rd_val = REG_DW'(q_base[rd_q[QSW-1:0]][ADDR_W-1:REG_DW]);
                RG_CTRL: begin
                    rd_val[REG_DW-1]          = q_act[rd_q[QSW-1:0]];
                    rd_val[CPL_LSB +: CPL_W]  = q_cpl[rd_q[QSW-1:0]];
                    rd_val[LOG_W-1:0]         = q_log[rd_q[QSW-1:0]];
                end
                RG_HEAD: rd_val = REG_DW'(q_head[rd_q[QSW-1:0]]);
                RG_TAIL: rd_val = REG_DW'(q_tailc[rd_q[QSW-1:0]]);
                default: rd_val = '0;
            endcase
        end
    end

    assert_resp_hold_R4: assert property (@(posedge clk) disable iff (rst)
        resp_valid && !resp_ready |=> resp_valid && $stable(resp_ptr) && $stable(resp_addr)
            && $stable(resp_op_tag) && $stable(resp_tag) && $stable(resp_empty) && $stable(resp_error));
    assert_no_req_during_resp_R4: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !req_ready);
    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !(resp_empty && resp_error));
    assert_full_stalls_R9: assert property (@(posedge clk) disable iff (rst)
        full |-> !req_ready);
    assert_doorbell_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        doorbell_valid |=> !doorbell_valid);
    assert_refused_no_tag_R6: assert property (@(posedge clk) disable iff (rst)
        resp_valid && (resp_empty || resp_error) |-> resp_op_tag == '0);
endmodule

// File: tb/sim_desc_queue_mgr.sv
`timescale 1ns/1ps
module sim_desc_queue_mgr;
    localparam int QUEUES = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1, en = 1'b1;
    logic [7:0]  dq_queue = '0, dq_tag = '0, c_tag = '0;
    logic        dq_valid = 1'b0, rsp_ready = 1'b0, c_valid = 1'b0;
    logic        req_ready, resp_valid, resp_empty, resp_error, commit_ready, db_valid;
    logic [7:0]  resp_queue, resp_cpl, resp_tag, resp_op_tag, db_queue;
    logic [15:0] resp_ptr;
    logic [63:0] resp_addr;
    logic [15:0] awaddr = '0, araddr = '0;
    logic [31:0] wdata = '0, rdata;
    logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic awready, wready, bvalid, arready, rvalid;

    desc_queue_mgr u0 (
        .clk(clk), .rst(rst), .enable(en),
        .req_queue(dq_queue), .req_tag(dq_tag), .req_valid(dq_valid), .req_ready(req_ready),
        .resp_queue(resp_queue), .resp_ptr(resp_ptr), .resp_addr(resp_addr), .resp_cpl(resp_cpl),
        .resp_tag(resp_tag), .resp_op_tag(resp_op_tag), .resp_empty(resp_empty),
        .resp_error(resp_error), .resp_valid(resp_valid), .resp_ready(rsp_ready),
        .commit_tag(c_tag), .commit_valid(c_valid), .commit_ready(commit_ready),
        .doorbell_queue(db_queue), .doorbell_valid(db_valid),
        .csr_awaddr(awaddr), .csr_awvalid(awvalid), .csr_awready(awready),
        .csr_wdata(wdata), .csr_wvalid(wvalid), .csr_wready(wready),
        .csr_bvalid(bvalid), .csr_bready(bready),
        .csr_araddr(araddr), .csr_arvalid(arvalid), .csr_arready(arready),
        .csr_rdata(rdata), .csr_rvalid(rvalid), .csr_rready(rready)
    );

    int checks = 0, errors = 0;

    // behavioural model
    logic [63:0] m_base [QUEUES];
    int m_log [QUEUES], m_cpl [QUEUES], m_act [QUEUES];
    int m_head [QUEUES], m_tails [QUEUES], m_tailc [QUEUES];
    bit busy [16];
    int owner [16];
    int outstanding = 0;
    bit in_flight = 0, resp_exp = 0, db_exp = 0;
    int db_qexp = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // per-clock comparison of handshake outputs
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            chk("R9 req_ready", req_ready, !in_flight && outstanding < 16);
            chk("R4 resp_valid", resp_valid, resp_exp);
            chk("R3 doorbell_valid", db_valid, db_exp);
            if (db_exp) chk("R3 doorbell_queue", db_queue, db_qexp);
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    function automatic logic [31:0] model_reg(input int addr);
        int q = addr >> 5;
        int r = (addr >> 2) & 7;
        if ((addr % 4) != 0 || q >= QUEUES) return 32'h0;
        case (r)
            0: return m_base[q][31:0];
            1: return m_base[q][63:32];
            2: return {m_act[q][0], 15'h0, m_cpl[q][7:0], 4'h0, m_log[q][3:0]};
            3: return 32'(m_head[q]);
            4: return 32'(m_tailc[q]);
            default: return 32'h0;
        endcase
    endfunction

    task automatic csr_write(input int addr, input logic [31:0] data);
        int q = addr >> 5;
        int r = (addr >> 2) & 7;
        awaddr = 16'(addr); wdata = data; awvalid = 1; wvalid = 1;
        @(posedge clk); @(negedge clk);
        awvalid = 0; wvalid = 0;
        chk("R2 bvalid", bvalid, 1);
        if ((addr % 4) == 0 && q < QUEUES) begin
            case (r)
                0: m_base[q][31:0] = data;
                1: m_base[q][63:32] = data;
                2: begin m_act[q] = data[31]; m_cpl[q] = data[15:8]; m_log[q] = data[3:0]; end
                3: begin m_head[q] = data[15:0]; db_exp = 1; db_qexp = q; end
                4: begin m_tails[q] = data[15:0]; m_tailc[q] = data[15:0]; end
                default: ;
            endcase
        end
        bready = 1;
        @(posedge clk); @(negedge clk);
        bready = 0; db_exp = 0;
        chk("R2 bvalid drop", bvalid, 0);
    endtask

    task automatic csr_read(input int addr, input string req);
        araddr = 16'(addr); arvalid = 1;
        @(posedge clk); @(negedge clk);
        arvalid = 0;
        chk({req, " rvalid"}, rvalid, 1);
        chk({req, " rdata"}, rdata, model_reg(addr));
        rready = 1;
        @(posedge clk); @(negedge clk);
        rready = 0;
    endtask

    task automatic commit(input int tag);
        c_tag = 8'(tag); c_valid = 1;
        @(posedge clk); @(negedge clk);
        c_valid = 0;
        if (tag < 16 && busy[tag]) begin
            busy[tag] = 0;
            m_tailc[owner[tag]] = (m_tailc[owner[tag]] + 1) & 16'hffff;
            outstanding--;
        end
    endtask

    task automatic deq(input int q, input int tag, input int hold, output int op);
        logic [63:0] e_ptr = 0, e_addr = 0, e_cpl = 0;
        bit e_err = 0, e_emp = 0, ok;
        string rq;
        op = 0;
        dq_queue = 8'(q); dq_tag = 8'(tag); dq_valid = 1;
        @(posedge clk); @(negedge clk);
        dq_valid = 0; in_flight = 1;
        @(posedge clk); @(negedge clk);
        resp_exp = 1;
        ok = en && q < QUEUES && m_act[q] != 0;
        if (!ok) begin
            e_err = 1; rq = "R7";
        end else begin
            e_ptr = 64'(m_tails[q]);
            e_addr = m_base[q] + ((e_ptr & ((64'd1 << m_log[q]) - 1)) << 4);
            e_cpl = 64'(m_cpl[q]);
            if (m_head[q] == m_tails[q]) begin
                e_emp = 1; rq = "R6";
            end else begin
                rq = "R5";
                for (int e = 15; e >= 0; e--) if (!busy[e]) op = e;
                busy[op] = 1; owner[op] = q; outstanding++;
                m_tails[q] = (m_tails[q] + 1) & 16'hffff;
            end
        end
        for (int h = 0; h <= hold; h++) begin
            string lab = (h == 0) ? rq : "R4 held";
            if (h > 0) begin @(posedge clk); @(negedge clk); end
            chk({lab, " queue"}, resp_queue, 64'(q & 8'hff));
            chk({lab, " tag"}, resp_tag, 64'(tag));
            chk({lab, " ptr"}, resp_ptr, e_ptr);
            chk({lab, " addr"}, resp_addr, e_addr);
            chk({lab, " cpl"}, resp_cpl, e_cpl);
            chk({lab, " op_tag"}, resp_op_tag, 64'(op));
            chk({lab, " empty"}, resp_empty, 64'(e_emp));
            chk({lab, " error"}, resp_error, 64'(e_err));
        end
        rsp_ready = 1;
        @(posedge clk); @(negedge clk);
        rsp_ready = 0; in_flight = 0; resp_exp = 0;
    endtask

    initial begin
        int op;
        for (int i = 0; i < QUEUES; i++) begin
            m_base[i] = 0; m_log[i] = 0; m_cpl[i] = 0; m_act[i] = 0;
            m_head[i] = 0; m_tails[i] = 0; m_tailc[i] = 0;
        end
        for (int e = 0; e < 16; e++) begin busy[e] = 0; owner[e] = 0; end
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        chk("R1 req_ready", req_ready, 1);
        chk("R1 resp_valid", resp_valid, 0);
        chk("R1 bvalid", bvalid, 0);
        chk("R1 rvalid", rvalid, 0);
        chk("R1 doorbell", db_valid, 0);
        chk("R1 commit_ready", commit_ready, 1);
        csr_read(0*32 + 8, "R1 ctrl");
        csr_read(3*32 + 16, "R1 tail");

        // R2 configuration and readback
        csr_write(0*32 + 0, 32'h8765_4000);
        csr_write(0*32 + 4, 32'h0000_00ab);
        csr_write(0*32 + 8, 32'h8000_2103);
        csr_write(2*32 + 0, 32'h0010_0000);
        csr_write(2*32 + 8, 32'h8000_4402);
        csr_write(1*32 + 0, 32'h0000_1000);
        csr_read(0*32 + 0, "R2 base lo");
        csr_read(0*32 + 4, "R2 base hi");
        csr_read(0*32 + 8, "R2 ctrl");
        csr_read(2*32 + 8, "R2 ctrl q2");
        csr_write(0*32 + 1, 32'hffff_ffff);
        csr_read(0*32 + 0, "R2 unaligned write ignored");
        csr_write(5*32 + 0, 32'h1234_5678);
        csr_read(5*32 + 0, "R2 out of range read");
        // R3 producer write rings the doorbell
        csr_write(0*32 + 12, 32'h0000_0005);
        csr_read(0*32 + 12, "R3 head");

        // R5, R4, R6, R7
        deq(0, 8'h11, 0, op);
        chk("R5 first op", op, 0);
        deq(0, 8'h12, 3, op);
        deq(2, 8'h13, 0, op);
        deq(1, 8'h14, 0, op);
        deq(9, 8'h15, 0, op);
        en = 0;
        deq(0, 8'h16, 0, op);
        en = 1;

        // R8 commit and ignored commits
        csr_read(0*32 + 16, "R8 tail before commit");
        commit(0);
        csr_read(0*32 + 16, "R8 tail after commit");
        commit(0);
        commit(200);
        csr_read(0*32 + 16, "R8 stale commit ignored");
        deq(0, 8'h17, 0, op);
        chk("R8 freed tag reused", op, 0);

        // R9 fill the table from ring 2 (size 4, offsets wrap: R11)
        csr_write(2*32 + 12, 32'h0000_0020);
        while (outstanding < 16) deq(2, 8'h20, 0, op);
        chk("R9 full stalls", req_ready, 0);
        commit(5);
        chk("R9 ready after commit", req_ready, 1);
        for (int e = 0; e < 16; e++) if (busy[e]) commit(e);
        csr_read(2*32 + 16, "R8 ring2 tail");

        // R10 / R11 consumer index write and wrap
        csr_write(0*32 + 16, 32'h0000_ffff);
        csr_write(0*32 + 12, 32'h0000_0001);
        csr_read(0*32 + 16, "R10 tail written");
        deq(0, 8'h30, 0, op);
        commit(op);
        csr_read(0*32 + 16, "R11 tail wraps");
        deq(0, 8'h31, 0, op);
        deq(0, 8'h32, 0, op);
        commit(op);
        csr_read(0*32 + 16, "R11 tail after wrap");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule